// File: doc/BRIEF.md
# PLL Frequency-Change Sequencer

This block retunes the PLL of one of four processor clusters without software stepping through the procedure. A single start pulse carries a cluster index and a frequency select code. The block then acts as a master on a 32-bit register bus and works through the cluster's clock/reset manager registers in a fixed, safe order. It moves the clock onto the bypass source and holds the PLL and its post-divider in reset. It programs the dividers and loop gains, then releases the PLL core and requests a VCO update. It polls for lock for a bounded time, releases the post-divider and finally returns the clock to the PLL output.

Each change to a shared control register is a read followed by a write that alters only the intended bits. Every bus access is one valid/ready handshake. A lock that never arrives does not stall the block: it raises an error flag and completes the remaining steps, so the cluster is never left in bypass or reset. The PLL itself is not modelled. Lock is learned only by reading the status register.

Top module: `psq_sequencer`

## Requirements
- R1: Every access goes to cluster base + register offset. The base is 0x6600_0000 + index × 0x2000 for indices 0–3, and 0x6600_0000 for any index of 4 or more. Offsets: bypass 0x0AC, power/reset 0x070, command 0x080, status 0x084, fractional-low 0x100, fractional-high 0x104, control-3 0x108, control-4 0x10C.
- R2: After an accepted start the accesses occur in this order: bypass on, both resets asserted, divider writes, PLL-core reset released, VCO update, status polls, post-divider reset released, bypass off.
- R3: The bypass, power/reset and command registers are each read before being written. The write changes only the target bits and keeps every other bit as read. The target bits are: bypass bit 0 (set to bypass, cleared to leave it), PLL-core reset-release bit 4, post-divider reset-release bit 5 (both cleared to assert reset), and VCO-update bit 0 (set).
- R4: Frequency select code 1 gives integer divider 0x78, code 2 gives 0x3C and code 3 gives 0x1E. Code 0 skips all four divider writes, and the rest of the sequence runs unchanged.
- R5: The divider writes are: fractional-low = 0 and fractional-high = 0. Control-3 carries the 10-bit integer divider in bits 9:0 and post divider 1 in bits 15:12. Control-4 = 0x0000C823, which packs proportional gain 3 at bit 0, integral gain 2 at bit 4, fast-lock gain 0 at bit 7 and reference info 50 at bit 10.
- R6: Before each status read the block waits at least POLL_WAIT cycles. Polling stops at the first read with bit 9 set. It makes at most POLL_MAX reads, and other status bits do not count as lock.
- R7: If POLL_MAX reads pass without lock, lock_err_o rises and the remaining steps still complete. The flag holds until the next accepted start clears it.
- R8: busy_o is high from the cycle after an accepted start until the sequence ends. A start pulse while busy is ignored, and bus_valid_o is only high while busy.
- R9: done_o is a single-cycle pulse, raised in the same cycle busy_o falls.
- R10: Once bus_valid_o is raised, it and the address, write-enable and write data stay unchanged until a cycle with bus_ready_i high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, sampled when idle |
| cluster_i | input | CL_W | Cluster index |
| fsel_i | input | 2 | Frequency select: 1 full, 2 half, 3 quarter, 0 none |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| lock_err_o | output | 1 | Lock was not seen within the poll limit |
| bus_valid_o | output | 1 | Bus access request |
| bus_write_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | 32 | Byte address |
| bus_wdata_o | output | 32 | Write data |
| bus_ready_i | input | 1 | Slave accepts the access this cycle |
| bus_rdata_i | input | 32 | Read data, valid with bus_ready_i on reads |

## Verification
The sequence is run for each of the three valid frequency codes and once for code 0. These runs separate the correct divider value from its neighbours and show that the divider writes are skipped when no valid code is given. Cluster indices 0, 2, 3 and 5 are used; index 5 shows the fallback base. The slave's register contents keep unrelated bits set, so any read-modify-write that disturbs a neighbour bit is visible in the write data. Lock is made to appear on the first poll, on a later poll and never, with a distractor status bit always set. These cases bound the poll count, the timeout flag and the completion of the remaining steps. Slave latency varies from access to access, and one stray start pulse arrives mid-run to test that it is ignored.

// File: rtl/psq_pkg.sv
// Shared types and constants for the PLL frequency-change sequencer.
// Assumes a 32-bit register bus and a fixed register layout per cluster.
package psq_pkg;

    localparam int BUS_W = 32;

    // Register offsets within one cluster window (decoded by the slave).
    localparam logic [11:0] OFF_PWR    = 12'h070;
    localparam logic [11:0] OFF_CMD    = 12'h080;
    localparam logic [11:0] OFF_STAT   = 12'h084;
    localparam logic [11:0] OFF_BYP    = 12'h0AC;
    localparam logic [11:0] OFF_FRACLO = 12'h100;
    localparam logic [11:0] OFF_FRACHI = 12'h104;
    localparam logic [11:0] OFF_DIV    = 12'h108;
    localparam logic [11:0] OFF_LOOP   = 12'h10C;

    localparam int LOCK_BIT = 9;
    localparam logic [BUS_W-1:0] M_BYP      = 32'h0000_0001;
    localparam logic [BUS_W-1:0] M_CORE_RST = 32'h0000_0010;
    localparam logic [BUS_W-1:0] M_POST_RST = 32'h0000_0020;
    localparam logic [BUS_W-1:0] M_VCO_UPD  = 32'h0000_0001;

    localparam logic [3:0] POST_DIV = 4'd1;
    localparam logic [BUS_W-1:0] LOOP_WORD =
        (32'd3 << 0) | (32'd2 << 4) | (32'd0 << 7) | (32'd50 << 10);

    typedef enum logic [3:0] {
        ST_IDLE, ST_BYP_SET, ST_RST_ON, ST_FRAC_LO, ST_FRAC_HI, ST_DIV_INT,
        ST_LOOP_CFG, ST_CORE_REL, ST_VCO_UPD, ST_WAIT, ST_POLL, ST_POST_REL,
        ST_BYP_CLR
    } step_e;

    typedef enum logic [1:0] {PH_RD_REQ, PH_RD_WAIT, PH_WR_REQ, PH_WR_WAIT} phase_e;

    typedef struct packed {
        logic             rmw;
        logic [11:0]      off;
        logic [BUS_W-1:0] set_m;
        logic [BUS_W-1:0] clr_m;
    } op_t;

    // Register target and bit masks of each bus step.
    function automatic op_t op_of(step_e s);
        op_t o;
        o = '{rmw: 1'b0, off: 12'h000, set_m: '0, clr_m: '0};
        case (s)
            ST_BYP_SET:  o = '{1'b1, OFF_BYP,    M_BYP,      32'h0};
            ST_RST_ON:   o = '{1'b1, OFF_PWR,    32'h0,      M_CORE_RST | M_POST_RST};
            ST_FRAC_LO:  o = '{1'b0, OFF_FRACLO, 32'h0,      32'h0};
            ST_FRAC_HI:  o = '{1'b0, OFF_FRACHI, 32'h0,      32'h0};
            ST_DIV_INT:  o = '{1'b0, OFF_DIV,    32'h0,      32'h0};
            ST_LOOP_CFG: o = '{1'b0, OFF_LOOP,   32'h0,      32'h0};
            ST_CORE_REL: o = '{1'b1, OFF_PWR,    M_CORE_RST, 32'h0};
            ST_VCO_UPD:  o = '{1'b1, OFF_CMD,    M_VCO_UPD,  32'h0};
            ST_POLL:     o = '{1'b0, OFF_STAT,   32'h0,      32'h0};
            ST_POST_REL: o = '{1'b1, OFF_PWR,    M_POST_RST, 32'h0};
            ST_BYP_CLR:  o = '{1'b1, OFF_BYP,    32'h0,      M_BYP};
            default:     o = '{1'b0, 12'h000,    32'h0,      32'h0};
        endcase
        return o;
    endfunction

    // Integer divider for a frequency code; bit 10 flags a valid code.
    function automatic logic [10:0] ndiv_of(logic [1:0] code);
        case (code)
            2'd1:    return {1'b1, 10'h078};
            2'd2:    return {1'b1, 10'h03C};
            2'd3:    return {1'b1, 10'h01E};
            default: return {1'b0, 10'h000};
        endcase
    endfunction

    // Step that follows a completed bus step.
    function automatic step_e step_after(step_e s, logic div_ok);
        case (s)
            ST_BYP_SET:  return ST_RST_ON;
            ST_RST_ON:   return div_ok ? ST_FRAC_LO : ST_CORE_REL;
            ST_FRAC_LO:  return ST_FRAC_HI;
            ST_FRAC_HI:  return ST_DIV_INT;
            ST_DIV_INT:  return ST_LOOP_CFG;
            ST_LOOP_CFG: return ST_CORE_REL;
            ST_CORE_REL: return ST_VCO_UPD;
            ST_VCO_UPD:  return ST_WAIT;
            ST_POST_REL: return ST_BYP_CLR;
            default:     return ST_IDLE;
        endcase
    endfunction

    // First bus phase of a step: read for RMW and polls, otherwise write.
    function automatic phase_e first_phase(step_e s);
        return (op_of(s).rmw || s == ST_POLL) ? PH_RD_REQ : PH_WR_REQ;
    endfunction

endpackage

// File: rtl/psq_base_map.sv
// Maps a cluster index to its register window base address.
// Assumes windows are evenly spaced; out-of-range indices use window 0.
module psq_base_map #(
    parameter int          CL_W         = 3,
    parameter int          NUM_CLUSTERS = 4,
    parameter logic [31:0] BASE_ADDR    = 32'h6600_0000,
    parameter logic [31:0] STRIDE       = 32'h0000_2000
) (
    input  logic [CL_W-1:0] cluster_i,
    output logic [31:0]     base_o
);
    // Select the window for a valid index, window 0 otherwise.
    always_comb begin
        base_o = BASE_ADDR;
        for (int i = 1; i < NUM_CLUSTERS; i++) begin
            if (cluster_i == CL_W'(i)) base_o = BASE_ADDR + STRIDE * 32'(i);
        end
    end
endmodule

// File: rtl/psq_bus_port.sv
// Single-access bus master port: holds one request on the valid/ready bus
// until accepted, then returns a one-cycle ack with the captured read data.
// Assumes the requester issues a new request only after the previous ack.
module psq_bus_port (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_i,
    input  logic        req_we_i,
    input  logic [31:0] req_addr_i,
    input  logic [31:0] req_wdata_i,
    output logic        ack_o,
    output logic [31:0] rdata_o,
    output logic        bus_valid_o,
    output logic        bus_write_o,
    output logic [31:0] bus_addr_o,
    output logic [31:0] bus_wdata_o,
    input  logic        bus_ready_i,
    input  logic [31:0] bus_rdata_i
);
    // Launch, hold and retire one access; capture read data on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_valid_o <= 1'b0;
            bus_write_o <= 1'b0;
            bus_addr_o  <= '0;
            bus_wdata_o <= '0;
            ack_o       <= 1'b0;
            rdata_o     <= '0;
        end else begin
            ack_o <= 1'b0;
            if (bus_valid_o) begin
                if (bus_ready_i) begin
                    bus_valid_o <= 1'b0;
                    ack_o       <= 1'b1;
                    rdata_o     <= bus_rdata_i;
                end
            end else if (req_i) begin
                bus_valid_o <= 1'b1;
                bus_write_o <= req_we_i;
                bus_addr_o  <= req_addr_i;
                bus_wdata_o <= req_wdata_i;
            end
        end
    end
endmodule

// File: rtl/psq_poll_timer.sv
// Lock-poll pacing: a wait counter that runs while enabled and expires
// after POLL_WAIT cycles, plus a count of failed polls.
// Assumes POLL_WAIT >= 1 and POLL_MAX >= 1.
module psq_poll_timer #(
    parameter int POLL_WAIT = 256,
    parameter int POLL_MAX  = 1500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic clr_i,
    input  logic inc_i,
    output logic expired_o,
    output logic last_o
);
    localparam int WAIT_W = $clog2(POLL_WAIT + 1);
    localparam int TRY_W  = $clog2(POLL_MAX + 1);

    logic [WAIT_W-1:0] wait_cnt;
    logic [TRY_W-1:0]  tries;

    // Count cycles spent waiting; restart whenever the wait is left.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) wait_cnt <= '0;
        else                  wait_cnt <= wait_cnt + 1'b1;
    end

    // Count unsuccessful polls of the current sequence.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) tries <= '0;
        else if (inc_i)      tries <= tries + 1'b1;
    end

    assign expired_o = run_i && (wait_cnt == WAIT_W'(POLL_WAIT - 1));
    assign last_o    = (tries == TRY_W'(POLL_MAX - 1));
endmodule

// File: rtl/psq_sequencer.sv
// PLL frequency-change sequencer top. On start it records the cluster
// window and divider and walks the fixed retune order over the register
// bus, one access at a time. Assumes the slave answers every access.
module psq_sequencer
    import psq_pkg::*;
#(
    parameter int          CL_W         = 3,
    parameter int          NUM_CLUSTERS = 4,
    parameter logic [31:0] BASE_ADDR    = 32'h6600_0000,
    parameter logic [31:0] STRIDE       = 32'h0000_2000,
    parameter int          POLL_WAIT    = 256,
    parameter int          POLL_MAX     = 1500
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [CL_W-1:0] cluster_i,
    input  logic [1:0]      fsel_i,
    output logic            busy_o,
    output logic            done_o,
    output logic            lock_err_o,
    output logic            bus_valid_o,
    output logic            bus_write_o,
    output logic [31:0]     bus_addr_o,
    output logic [31:0]     bus_wdata_o,
    input  logic            bus_ready_i,
    input  logic [31:0]     bus_rdata_i
);
    step_e       step;
    phase_e      phase;
    logic [31:0] base_q;
    logic [9:0]  ndiv_q;
    logic        div_ok_q;
    logic        err_q;
    logic        done_q;

    logic [31:0] base_w;
    logic [10:0] ndiv_w;
    op_t         op;
    logic        req, ack, expired, last_try, lock_seen, poll_fail;
    logic [31:0] rdata, wdata;

    psq_base_map #(
        .CL_W(CL_W), .NUM_CLUSTERS(NUM_CLUSTERS),
        .BASE_ADDR(BASE_ADDR), .STRIDE(STRIDE)
    ) u_map (
        .cluster_i(cluster_i), .base_o(base_w)
    );

    psq_poll_timer #(.POLL_WAIT(POLL_WAIT), .POLL_MAX(POLL_MAX)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .run_i(step == ST_WAIT), .clr_i(step == ST_IDLE), .inc_i(poll_fail),
        .expired_o(expired), .last_o(last_try)
    );

    psq_bus_port u_port (
        .clk(clk), .rst_n(rst_n),
        .req_i(req), .req_we_i(phase == PH_WR_REQ),
        .req_addr_i(base_q + 32'(op.off)), .req_wdata_i(wdata),
        .ack_o(ack), .rdata_o(rdata),
        .bus_valid_o(bus_valid_o), .bus_write_o(bus_write_o),
        .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o),
        .bus_ready_i(bus_ready_i), .bus_rdata_i(bus_rdata_i)
    );

    assign ndiv_w    = ndiv_of(fsel_i);
    assign op        = op_of(step);
    assign lock_seen = rdata[LOCK_BIT];
    assign poll_fail = (step == ST_POLL) && (phase == PH_RD_WAIT) && ack && !lock_seen;
    assign req       = (step != ST_IDLE) && (step != ST_WAIT) &&
                       (phase == PH_RD_REQ || phase == PH_WR_REQ);

    // Write data: fixed words for divider steps, masked read data otherwise.
    always_comb begin
        case (step)
            ST_FRAC_LO, ST_FRAC_HI: wdata = '0;
            ST_DIV_INT:  wdata = {16'h0, POST_DIV, 2'b00, ndiv_q};
            ST_LOOP_CFG: wdata = LOOP_WORD;
            default:     wdata = (rdata & ~op.clr_m) | op.set_m;
        endcase
    end

    // Step and phase sequencing, lock decision and result flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step     <= ST_IDLE;
            phase    <= PH_RD_REQ;
            base_q   <= '0;
            ndiv_q   <= '0;
            div_ok_q <= 1'b0;
            err_q    <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (step)
                ST_IDLE: begin
                    if (start_i) begin
                        base_q   <= base_w;
                        div_ok_q <= ndiv_w[10];
                        ndiv_q   <= ndiv_w[9:0];
                        err_q    <= 1'b0;
                        step     <= ST_BYP_SET;
                        phase    <= PH_RD_REQ;
                    end
                end
                ST_WAIT: begin
                    if (expired) begin
                        step  <= ST_POLL;
                        phase <= PH_RD_REQ;
                    end
                end
                default: begin
                    case (phase)
                        PH_RD_REQ: phase <= PH_RD_WAIT;
                        PH_WR_REQ: phase <= PH_WR_WAIT;
                        PH_RD_WAIT: begin
                            if (ack) begin
                                if (step != ST_POLL) begin
                                    phase <= PH_WR_REQ;
                                end else if (lock_seen || last_try) begin
                                    if (!lock_seen) err_q <= 1'b1;
                                    step  <= ST_POST_REL;
                                    phase <= PH_RD_REQ;
                                end else begin
                                    step <= ST_WAIT;
                                end
                            end
                        end
                        PH_WR_WAIT: begin
                            if (ack) begin
                                if (step == ST_BYP_CLR) begin
                                    step   <= ST_IDLE;
                                    done_q <= 1'b1;
                                end else begin
                                    step  <= step_after(step, div_ok_q);
                                    phase <= first_phase(step_after(step, div_ok_q));
                                end
                            end
                        end
                        default: phase <= PH_RD_REQ;
                    endcase
                end
            endcase
        end
    end

    assign busy_o     = (step != ST_IDLE);
    assign done_o     = done_q;
    assign lock_err_o = err_q;
endmodule

// File: rtl/psq_sequencer_chk.sv
// Protocol checker for psq_sequencer, attached by bind.
// Assumes synchronous active-low reset; all properties are off in reset.
module psq_sequencer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy_o,
    input logic        done_o,
    input logic        lock_err_o,
    input logic        bus_valid_o,
    input logic        bus_write_o,
    input logic [31:0] bus_addr_o,
    input logic [31:0] bus_wdata_o,
    input logic        bus_ready_i
);
    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid_o && !bus_ready_i |=> bus_valid_o && $stable(bus_addr_o) &&
        $stable(bus_wdata_o) && $stable(bus_write_o));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $fell(busy_o));

    // R8
    valid_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid_o |-> busy_o);

    // R1
    addr_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid_o |-> (bus_addr_o & 32'hFFFF_9E00) == 32'h6600_0000);

    // R7
    err_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_err_o) |-> busy_o);
endmodule

bind psq_sequencer psq_sequencer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .done_o(done_o),
    .lock_err_o(lock_err_o), .bus_valid_o(bus_valid_o),
    .bus_write_o(bus_write_o), .bus_addr_o(bus_addr_o),
    .bus_wdata_o(bus_wdata_o), .bus_ready_i(bus_ready_i)
);

// File: tb/psq_sequencer_test.sv
// Scoreboard bench: the driver task queues the expected bus accesses of
// each run, and the slave/monitor pops and compares them as they complete.
module psq_sequencer_test;
    localparam int PW = 4;
    localparam int PM = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  cluster_i = '0;
    logic [1:0]  fsel_i = '0;
    logic        busy_o, done_o, lock_err_o;
    logic        bus_valid_o, bus_write_o;
    logic [31:0] bus_addr_o, bus_wdata_o;
    logic        bus_ready_i = 1'b0;
    logic [31:0] bus_rdata_i = '0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    typedef struct packed {
        logic        we;
        logic [31:0] addr;
        logic [31:0] data;
    } item_t;
    item_t exp_q[$];

    logic [31:0] mem [logic [31:0]];
    int lock_after = 1;
    int poll_n = 0;
    int last_poll = -1;

    psq_sequencer #(.POLL_WAIT(PW), .POLL_MAX(PM)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cluster_i(cluster_i),
        .fsel_i(fsel_i), .busy_o(busy_o), .done_o(done_o),
        .lock_err_o(lock_err_o), .bus_valid_o(bus_valid_o),
        .bus_write_o(bus_write_o), .bus_addr_o(bus_addr_o),
        .bus_wdata_o(bus_wdata_o), .bus_ready_i(bus_ready_i),
        .bus_rdata_i(bus_rdata_i)
    );

    always #10 clk = ~clk;

    initial forever begin
        @(posedge clk);
        cyc++;
    end

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic push(input logic we, input logic [31:0] a, input logic [31:0] d);
        exp_q.push_back('{we: we, addr: a, data: d});
    endtask

    // Check one completed access against the scoreboard and apply it.
    task automatic complete(input logic we, input logic [31:0] a, input logic [31:0] d);
        item_t e;
        if (exp_q.size() == 0) begin
            chk(1'b0, "R2 unexpected access", a, 32'h0);
            return;
        end
        e = exp_q.pop_front();
        chk(we == e.we && a == e.addr, "R1 R2 R4 access order/address",
            {a[31:1], we}, {e.addr[31:1], e.we});
        if (we && e.we && a == e.addr) begin
            if (a[11:0] >= 12'h100) chk(d == e.data, "R5 divider word", d, e.data);
            else                    chk(d == e.data, "R3 rmw write data", d, e.data);
        end
        if (we) mem[a] = d;
        if (!we && a[11:0] == 12'h084) begin
            if (last_poll >= 0)
                chk(cyc - last_poll >= PW, "R6 poll spacing", cyc - last_poll, PW);
            last_poll = cyc;
            poll_n++;
        end
    endtask

    // Bus slave with varying latency; completes accesses at the negedge after acceptance.
    initial begin
        logic        c_we;
        logic [31:0] c_addr, c_data;
        int          wcnt, nacc;
        wcnt = 0; nacc = 0; c_we = 0; c_addr = 0; c_data = 0;
        forever begin
            @(negedge clk);
            if (bus_ready_i) begin
                complete(c_we, c_addr, c_data);
                bus_ready_i = 1'b0;
            end else if (bus_valid_o) begin
                if (wcnt >= nacc % 3) begin
                    c_we = bus_write_o; c_addr = bus_addr_o; c_data = bus_wdata_o;
                    if (bus_addr_o[11:0] == 12'h084)
                        bus_rdata_i = (lock_after != 0 && poll_n + 1 >= lock_after)
                                      ? 32'h0000_0300 : 32'h0000_0100;
                    else
                        bus_rdata_i = mem.exists(bus_addr_o) ? mem[bus_addr_o] : 32'h0;
                    bus_ready_i = 1'b1;
                    wcnt = 0;
                    nacc++;
                end else begin
                    wcnt++;
                end
            end
        end
    end

    // Driver: queue the expected accesses of one run, start it, check the end.
    task automatic run(input logic [2:0] cl, input logic [1:0] fs, input int lk,
                       input bit ghost, input string tag);
        logic [31:0] b;
        logic [9:0]  nd;
        int          n;
        bit          seen;
        b = (cl < 4) ? 32'h6600_0000 + 32'(cl) * 32'h2000 : 32'h6600_0000;
        mem[b + 32'h0AC] = 32'h0000_EC1E;
        mem[b + 32'h070] = 32'h0000_00FF;
        mem[b + 32'h080] = 32'h0000_0A00;
        lock_after = lk; poll_n = 0; last_poll = -1;
        push(0, b + 32'h0AC, 0); push(1, b + 32'h0AC, 32'h0000_EC1F);
        push(0, b + 32'h070, 0); push(1, b + 32'h070, 32'h0000_00CF);
        nd = (fs == 1) ? 10'h078 : (fs == 2) ? 10'h03C : 10'h01E;
        if (fs != 0) begin
            push(1, b + 32'h100, 0); push(1, b + 32'h104, 0);
            push(1, b + 32'h108, {20'h00001, 2'b00, nd});
            push(1, b + 32'h10C, 32'h0000_C823);
        end
        push(0, b + 32'h070, 0); push(1, b + 32'h070, 32'h0000_00DF);
        push(0, b + 32'h080, 0); push(1, b + 32'h080, 32'h0000_0A01);
        n = (lk == 0) ? PM : lk;
        for (int i = 0; i < n; i++) push(0, b + 32'h084, 0);
        push(0, b + 32'h070, 0); push(1, b + 32'h070, 32'h0000_00FF);
        push(0, b + 32'h0AC, 0); push(1, b + 32'h0AC, 32'h0000_EC1E);

        @(negedge clk);
        cluster_i = cl; fsel_i = fs; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, {"R8 busy after start ", tag}, busy_o, 1);
        chk(lock_err_o == 1'b0, {"R7 flag cleared by start ", tag}, lock_err_o, 0);
        if (ghost) begin
            repeat (3) @(negedge clk);
            cluster_i = 3'd3; fsel_i = 2'd3; start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        seen = 0;
        for (int i = 0; i < 5000 && !seen; i++) begin
            @(negedge clk);
            if (done_o) seen = 1;
        end
        chk(seen, {"R9 done seen ", tag}, seen, 1);
        chk(busy_o == 1'b0, {"R9 busy low with done ", tag}, busy_o, 0);
        chk(lock_err_o == (lk == 0), {"R7 lock error flag ", tag}, lock_err_o, 32'(lk == 0));
        @(negedge clk);
        chk(done_o == 1'b0, {"R9 done one cycle ", tag}, done_o, 0);
        chk(exp_q.size() == 0, {"R2 R8 all accesses made ", tag}, exp_q.size(), 0);
        chk(lock_err_o == (lk == 0), {"R7 flag held ", tag}, lock_err_o, 32'(lk == 0));
        repeat (4) @(negedge clk);
        chk(bus_valid_o == 1'b0 && busy_o == 1'b0, {"R8 idle after run ", tag},
            {bus_valid_o, busy_o}, 0);
        exp_q.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(busy_o == 0 && done_o == 0 && lock_err_o == 0 && bus_valid_o == 0,
            "R8 reset state", {busy_o, done_o, lock_err_o, bus_valid_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        run(3'd0, 2'd1, 2, 1'b0, "c0 full");
        run(3'd2, 2'd2, 1, 1'b1, "c2 half ghost-start");
        run(3'd3, 2'd3, 0, 1'b0, "c3 quarter no-lock");
        run(3'd1, 2'd0, 3, 1'b0, "c1 invalid code");
        run(3'd5, 2'd1, 1, 1'b0, "idx5 fallback");
        run(3'd1, 2'd3, PM, 1'b0, "c1 lock on last poll");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule